// File: doc/BRIEF.md
# DAC Bring-Up and Clear-Verify Sequencer

This block is the host side of a serial link to a precision voltage-output DAC. A single `start` pulse makes it drive a fixed six-frame script over a three-wire serial port (clock, active-low frame select, data out), with a fourth wire returning readback data.

The script has six steps in a fixed order:

1. Configure the DAC for offset-binary coding, with the output released from its ground clamp and from tristate.
2. Load a midscale code.
3. Store a full-scale clear code.
4. Fire the software clear, so the output jumps to that clear code.
5. Request a read of the clear-code register.
6. Send a no-operation frame, during which the reply is captured.

After the last frame the sequencer compares the reply with the full-scale code it wrote, limited to the bits the DAC resolution defines. It raises `done` and reports the verdict on `pass`.

The resolution (16, 18 or 20 bits) is a parameter. It decides which trailing data bits are don't-care; those bits are transmitted as zeros and ignored on compare. The serial clock rate is set by a divider parameter. The inter-frame idle time is set by a gap parameter.

Top module: `dac_init_seq`

## Requirements
- R1: Every frame holds exactly 24 falling edges of `sclk`, all inside one low period of `sync_n`, and data is sent MSB first.
- R2: `sclk` rests high whenever `sync_n` is high. `sdin` changes only when `sclk` rises or when `sync_n` falls, and never while `sclk` stays low.
- R3: Between two frames, `sync_n` stays high for at least 2·`GAP_PERIODS` half periods of `sclk`, which is at least 2·`GAP_PERIODS`·`CLK_DIV` clock cycles.
- R4: A start sends six 24-bit words in this order:
  - 0x200012: control write, offset binary, unclamped, out of tristate, readback enabled, amplifier bit 1.
  - 0x180000: DAC register write, midscale.
  - 0x3FFFFF: clear-code write, full scale, at 20 bits.
  - 0x400002: software control write with the clear bit (bit 1).
  - 0xB00000: clear-code read (bit 23 = 1, address bits [22:20] = 011).
  - 0x000000: no-operation.
- R5: Below 20-bit resolution, the data bits under the resolution are sent as zero. Examples: the clear-code word is 0x3FFFF0 at 16 bits, and the midscale word stays 0x180000.
- R6: `sdo` is sampled on each falling `sclk` edge of the no-operation frame, bit 23 first. `pass` is 1 only if bits [22:20] are 011 and data bits [19:0] match the full-scale code on the bits the resolution defines. Bit 23 and the bits below the resolution are ignored.
- R7: `done` and `pass` hold their values until the next accepted `start`, which clears both. `pass` is never 1 while `done` is 0.
- R8: A `start` pulse arriving while a script is running is ignored, so no extra frames are sent.
- R9: While reset is held, `sclk` = 1, `sync_n` = 1, `sdin` = 0, `done` = 0 and `pass` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that launches the script |
| sdo | input | 1 | Serial readback from the DAC |
| sclk | output | 1 | Serial clock to the DAC, idles high |
| sync_n | output | 1 | Active-low frame select |
| sdin | output | 1 | Serial command data to the DAC |
| done | output | 1 | Script finished; held until the next start |
| pass | output | 1 | Readback matched; valid while done is 1 |

## Verification
The bench runs a 20-bit and a 16-bit instance against a behavioural DAC model that records every frame and can flip chosen bits of its reply.

It aims at four corner cases:
- **Masking.** Flipped bits under the 16-bit resolution, or in bit 23, must still give a pass. A design that compared all 24 bits would report a false failure.
- **Real mismatches.** A flipped defined data bit, or a wrong address field, must give a fail. A design that checked only the data, or sampled on the wrong edge, would still pass.
- **Restart during a run.** A second start mid-script must not add frames. A design that restarted would send more than six.
- **Serial timing.** Idle gap length and `sdin` stability while `sclk` is low are watched continuously, because the wrong launch edge corrupts the words the model captures.

// File: rtl/dac_seq_pkg.sv
`timescale 1ns/1ps
package dac_seq_pkg;
   localparam int FRAME_W = 24;
   localparam int DATA_W  = 20;
   localparam int N_STEPS = 6;

   typedef enum logic [2:0] {
      REG_NOP   = 3'd0,
      REG_DAC   = 3'd1,
      REG_CTRL  = 3'd2,
      REG_CLEAR = 3'd3,
      REG_SWCTL = 3'd4
   } reg_sel_e;

   // control-register bit positions decoded by the DAC
   localparam int CTL_AMP_OFF = 1;
   localparam int CTL_OFFBIN  = 4;
   // software-control clear bit
   localparam int SW_CLEAR    = 1;

   function automatic logic [DATA_W-1:0] res_mask(input int res);
      logic [DATA_W-1:0] m;
      m = '0;
      for (int b = 0; b < DATA_W; b++)
         if (b >= DATA_W - res) m[b] = 1'b1;
      return m;
   endfunction

   function automatic logic [FRAME_W-1:0] step_word(input int res, input logic [2:0] idx);
      logic [DATA_W-1:0] d;
      case (idx)
         3'd0: begin
            d = '0;
            d[CTL_OFFBIN]  = 1'b1;
            d[CTL_AMP_OFF] = 1'b1;
            return {1'b0, REG_CTRL, d};
         end
         3'd1: begin
            d = '0;
            d[DATA_W-1] = 1'b1;
            return {1'b0, REG_DAC, d};
         end
         3'd2: return {1'b0, REG_CLEAR, res_mask(res)};
         3'd3: begin
            d = '0;
            d[SW_CLEAR] = 1'b1;
            return {1'b0, REG_SWCTL, d};
         end
         3'd4: return {1'b1, REG_CLEAR, {DATA_W{1'b0}}};
         default: return {1'b0, REG_NOP, {DATA_W{1'b0}}};
      endcase
   endfunction
endpackage

// File: rtl/dac_seq_tick.sv
`timescale 1ns/1ps
module dac_seq_tick #(
   parameter int DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   generate
      if (DIV == 1) begin : g_direct
         assign tick = run;
      end else begin : g_count
         localparam int CW = $clog2(DIV);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     cnt <= '0;
            else if (!run)                  cnt <= '0;
            else if (cnt == CW'(DIV - 1))   cnt <= '0;
            else                            cnt <= cnt + 1'b1;
         end
         assign tick = run && (cnt == CW'(DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/dac_seq_frame.sv
`timescale 1ns/1ps
module dac_seq_frame
   import dac_seq_pkg::*;
#(
   parameter int CLK_DIV     = 2,
   parameter int GAP_PERIODS = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go,
   input  logic [FRAME_W-1:0] word,
   input  logic               sdo,
   output logic               sclk,
   output logic               sync_n,
   output logic               sdin,
   output logic               fin,
   output logic [FRAME_W-1:0] rx
);
   localparam int GAP_TICKS = 2 * GAP_PERIODS;
   localparam int BCW       = $clog2(FRAME_W + 1);
   localparam int GCW       = $clog2(GAP_TICKS + 1);

   typedef enum logic [1:0] {E_IDLE, E_SHIFT, E_GAP} eng_e;
   eng_e             st;
   logic [FRAME_W-1:0] sh;
   logic [BCW-1:0]   nbit;
   logic [GCW-1:0]   gcnt;
   logic             tick;

   dac_seq_tick #(.DIV(CLK_DIV)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (st != E_IDLE),
      .tick (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= E_IDLE;
         sclk   <= 1'b1;
         sync_n <= 1'b1;
         sdin   <= 1'b0;
         sh     <= '0;
         rx     <= '0;
         nbit   <= '0;
         gcnt   <= '0;
         fin    <= 1'b0;
      end else begin
         fin <= 1'b0;
         case (st)
            E_IDLE: if (go) begin
               sync_n <= 1'b0;
               sdin   <= word[FRAME_W-1];
               sh     <= {word[FRAME_W-2:0], 1'b0};
               nbit   <= '0;
               st     <= E_SHIFT;
            end
            E_SHIFT: if (tick) begin
               if (sclk) begin
                  if (nbit == BCW'(FRAME_W)) begin
                     sync_n <= 1'b1;
                     gcnt   <= '0;
                     st     <= E_GAP;
                  end else begin
                     sclk <= 1'b0;
                     rx   <= {rx[FRAME_W-2:0], sdo};
                     nbit <= nbit + 1'b1;
                  end
               end else begin
                  sclk <= 1'b1;
                  sdin <= sh[FRAME_W-1];
                  sh   <= {sh[FRAME_W-2:0], 1'b0};
               end
            end
            E_GAP: if (tick) begin
               if (gcnt == GCW'(GAP_TICKS - 1)) begin
                  fin <= 1'b1;
                  st  <= E_IDLE;
               end else begin
                  gcnt <= gcnt + 1'b1;
               end
            end
            default: st <= E_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dac_init_seq.sv
`timescale 1ns/1ps
module dac_init_seq
   import dac_seq_pkg::*;
#(
   parameter int RES_BITS    = 20,
   parameter int CLK_DIV     = 2,
   parameter int GAP_PERIODS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic sdo,
   output logic sclk,
   output logic sync_n,
   output logic sdin,
   output logic done,
   output logic pass
);
   localparam logic [DATA_W-1:0] FS_MASK = res_mask(RES_BITS);

   generate
      if (!(RES_BITS == 16 || RES_BITS == 18 || RES_BITS == 20)) begin : g_bad_res
         $error("RES_BITS must be 16, 18 or 20");
      end
      if (CLK_DIV < 1) begin : g_bad_div
         $error("CLK_DIV must be at least 1");
      end
      if (GAP_PERIODS < 2) begin : g_bad_gap
         $error("GAP_PERIODS must be at least 2");
      end
   endgenerate

   typedef enum logic [1:0] {T_IDLE, T_ISSUE, T_WAIT} top_e;
   top_e               st;
   logic [2:0]         idx;
   logic               go;
   logic               fin;
   logic [FRAME_W-1:0] rx;
   logic               rx_ok;

   assign go = (st == T_ISSUE);

   dac_seq_frame #(.CLK_DIV(CLK_DIV), .GAP_PERIODS(GAP_PERIODS)) u_frame (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (go),
      .word  (step_word(RES_BITS, idx)),
      .sdo   (sdo),
      .sclk  (sclk),
      .sync_n(sync_n),
      .sdin  (sdin),
      .fin   (fin),
      .rx    (rx)
   );

   generate
      if (RES_BITS == DATA_W) begin : g_cmp_full
         assign rx_ok = (rx[FRAME_W-2:DATA_W] == REG_CLEAR) &&
                        (rx[DATA_W-1:0] == FS_MASK);
      end else begin : g_cmp_masked
         assign rx_ok = (rx[FRAME_W-2:DATA_W] == REG_CLEAR) &&
                        ((rx[DATA_W-1:0] & FS_MASK) == FS_MASK);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= T_IDLE;
         idx  <= '0;
         done <= 1'b0;
         pass <= 1'b0;
      end else begin
         case (st)
            T_IDLE: if (start) begin
               done <= 1'b0;
               pass <= 1'b0;
               idx  <= '0;
               st   <= T_ISSUE;
            end
            T_ISSUE: st <= T_WAIT;
            T_WAIT: if (fin) begin
               if (idx == 3'(N_STEPS - 1)) begin
                  done <= 1'b1;
                  pass <= rx_ok;
                  st   <= T_IDLE;
               end else begin
                  idx <= idx + 1'b1;
                  st  <= T_ISSUE;
               end
            end
            default: st <= T_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dac_init_seq_chk.sv
`timescale 1ns/1ps
module dac_init_seq_chk #(
   parameter int CLK_DIV     = 2,
   parameter int GAP_PERIODS = 2
) (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic sclk,
   input logic sync_n,
   input logic sdin,
   input logic done,
   input logic pass
);
   localparam int MIN_HIGH = 2 * GAP_PERIODS * CLK_DIV;

   logic        sclk_q;
   logic [5:0]  fall_cnt;
   logic [15:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q   <= 1'b1;
         fall_cnt <= '0;
         hi_cnt   <= '1;
      end else begin
         sclk_q <= sclk;
         if (sync_n)                fall_cnt <= '0;
         else if (sclk_q && !sclk)  fall_cnt <= fall_cnt + 1'b1;
         if (!sync_n)               hi_cnt <= '0;
         else if (!(&hi_cnt))       hi_cnt <= hi_cnt + 1'b1;
      end
   end

   a_r1_frame_24_falls: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync_n) |-> (fall_cnt == 6'd24));

   a_r2_sclk_rests_high: assert property (@(posedge clk) disable iff (!rst_n)
      sync_n |-> sclk);

   a_r2_sdin_held_while_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!sclk && !$past(sclk)) |-> $stable(sdin));

   a_r3_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sync_n) |-> (int'(hi_cnt) >= MIN_HIGH));

   a_r7_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);

   a_r7_pass_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
      pass |-> done);
endmodule

bind dac_init_seq dac_init_seq_chk #(.CLK_DIV(CLK_DIV), .GAP_PERIODS(GAP_PERIODS)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .sclk(sclk),
   .sync_n(sync_n), .sdin(sdin), .done(done), .pass(pass)
);

// File: tb/dac_init_seq_bench.sv
`timescale 1ns/1ps
module dac_slave_model (
   input  logic        sclk,
   input  logic        sync_n,
   input  logic        sdin,
   input  logic [23:0] flip,
   output logic        sdo,
   output logic [23:0] log_w [64],
   output int          nfr
);
   logic [23:0] in_sh;
   logic [23:0] out_sh;
   logic [19:0] cc;
   logic        rd_pend;
   int          cnt;

   initial begin
      sdo = 1'b0; nfr = 0; cnt = 0; rd_pend = 1'b0; cc = '0;
      in_sh = '0; out_sh = '0;
      for (int i = 0; i < 64; i++) log_w[i] = '0;
   end

   always @(negedge sync_n) begin
      cnt = 0;
      out_sh = rd_pend ? ({1'b1, 3'b011, cc} ^ flip) : 24'h0;
      rd_pend = 1'b0;
      sdo = out_sh[23];
   end

   always @(negedge sclk) if (!sync_n) begin
      in_sh = {in_sh[22:0], sdin};
      cnt++;
   end

   always @(posedge sclk) if (!sync_n) begin
      out_sh = {out_sh[22:0], 1'b0};
      sdo = out_sh[23];
   end

   always @(posedge sync_n) if (cnt == 24) begin
      log_w[nfr % 64] = in_sh;
      nfr++;
      if (in_sh[22:20] == 3'b011) begin
         if (in_sh[23]) rd_pend = 1'b1;
         else           cc = in_sh[19:0];
      end
   end
endmodule

module dac_init_seq_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start20 = 1'b0, start16 = 1'b0;
   logic [23:0] flip20 = '0, flip16 = '0;
   logic sdo20, sclk20, sync20, sdin20, done20, pass20;
   logic sdo16, sclk16, sync16, sdin16, done16, pass16;
   logic [23:0] log20 [64];
   logic [23:0] log16 [64];
   int nfr20, nfr16;
   int n_chk = 0, n_bad = 0, cycles = 0;
   int r2_viol = 0, min_high = 1000000, high_run = 1000000;
   logic prev_sclk = 1'b1, prev_sdin = 1'b0;

   localparam logic [23:0] EXP20 [6] = '{24'h200012, 24'h180000, 24'h3FFFFF,
                                         24'h400002, 24'hB00000, 24'h000000};
   localparam logic [23:0] EXP16 [6] = '{24'h200012, 24'h180000, 24'h3FFFF0,
                                         24'h400002, 24'hB00000, 24'h000000};

   always #2.5 clk = ~clk;

   dac_init_seq u_dac_init_seq (
      .clk(clk), .rst_n(rst_n), .start(start20), .sdo(sdo20),
      .sclk(sclk20), .sync_n(sync20), .sdin(sdin20), .done(done20), .pass(pass20));
   dac_init_seq #(.RES_BITS(16)) u_dac_init_seq_r16 (
      .clk(clk), .rst_n(rst_n), .start(start16), .sdo(sdo16),
      .sclk(sclk16), .sync_n(sync16), .sdin(sdin16), .done(done16), .pass(pass16));

   dac_slave_model u_dac20 (.sclk(sclk20), .sync_n(sync20), .sdin(sdin20), .flip(flip20),
                            .sdo(sdo20), .log_w(log20), .nfr(nfr20));
   dac_slave_model u_dac16 (.sclk(sclk16), .sync_n(sync16), .sdin(sdin16), .flip(flip16),
                            .sdo(sdo16), .log_w(log16), .nfr(nfr16));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   // serial timing monitor (R2, R3) on the 20-bit instance
   always @(negedge clk) if (rst_n) begin
      if (!prev_sclk && !sclk20 && (sdin20 !== prev_sdin)) r2_viol++;
      if (sync20) high_run++;
      else begin
         if (high_run != 0 && high_run < min_high) min_high = high_run;
         high_run = 0;
      end
      prev_sclk = sclk20;
      prev_sdin = sdin20;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         finish_run();
      end
   end

   task automatic run_both(input logic [23:0] f20, input logic [23:0] f16);
      @(negedge clk);
      flip20 = f20; flip16 = f16;
      start20 = 1'b1; start16 = 1'b1;
      @(negedge clk);
      start20 = 1'b0; start16 = 1'b0;
      for (int i = 0; i < 20000 && !(done20 && done16); i++) @(negedge clk);
   endtask

   initial begin
      int base;
      // R9: reset state
      repeat (3) @(negedge clk);
      chk("R9 sclk", sclk20, 1); chk("R9 sync_n", sync20, 1);
      chk("R9 sdin", sdin20, 0); chk("R9 done", done20, 0); chk("R9 pass", pass20, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R4/R5: table walk of the script words
      run_both(24'h0, 24'h0);
      chk("R1 frames seen 20b", nfr20, 6);
      chk("R1 frames seen 16b", nfr16, 6);
      for (int i = 0; i < 6; i++) chk("R4 word 20b", log20[i], EXP20[i]);
      for (int i = 0; i < 6; i++) chk("R5 word 16b", log16[i], EXP16[i]);
      chk("R6 pass 20b", pass20, 1);
      chk("R6 pass 16b", pass16, 1);
      chk("R2 sdin stable while sclk low", r2_viol, 0);
      chk("R3 gap at least 8 cycles", (min_high >= 8), 1);

      // R7: held flags
      repeat (200) @(negedge clk);
      chk("R7 done held", done20, 1);
      chk("R7 pass held", pass20, 1);

      // R7: start clears; R8: second start ignored
      base = nfr20;
      @(negedge clk); start20 = 1'b1; @(negedge clk); start20 = 1'b0;
      repeat (2) @(negedge clk);
      chk("R7 done cleared", done20, 0);
      chk("R7 pass cleared", pass20, 0);
      repeat (150) @(negedge clk);
      start20 = 1'b1; @(negedge clk); start20 = 1'b0;
      for (int i = 0; i < 20000 && !done20; i++) @(negedge clk);
      repeat (400) @(negedge clk);
      chk("R8 no extra frames", nfr20 - base, 6);

      // R6: readback corruption cases
      run_both(24'h000001, 24'h00000F);
      chk("R6 lsb flip fails 20b", pass20, 0);
      chk("R6 done on fail", done20, 1);
      chk("R6 sub-res flip passes 16b", pass16, 1);
      run_both(24'h100000, 24'h000010);
      chk("R6 address flip fails 20b", pass20, 0);
      chk("R6 defined bit flip fails 16b", pass16, 0);
      run_both(24'h800000, 24'h800000);
      chk("R6 bit23 ignored 20b", pass20, 1);
      chk("R6 bit23 ignored 16b", pass16, 1);
      chk("R2 sdin stable final", r2_viol, 0);
      chk("R3 gap final", (min_high >= 8), 1);
      finish_run();
   end
endmodule